// File: doc/BRIEF.md
# Multiplexed Memory Address Cycle Controller

This block divides its input clock into machine cycles of eight clocks and, in each one, sends a 16-bit memory address out over eight shared address pins. The upper byte goes out first, while a one-clock latch strobe tells external logic to capture it. The lower byte then replaces it on the same pins for the rest of the cycle. Together, the external latch and the pins give the memory a full 16-bit address.

A read/write request is sampled once per cycle, at the clock edge that starts a new cycle. A read cycle holds the active-low read level for the whole cycle. A write cycle issues a positive write pulse late in the cycle, after the low byte has been stable for several clocks. When no request is presented, the cycle is idle and neither strobe is active.

Top module: `mem_cycle_ctrl`

## Requirements
- R1: While rst_ni is low, and immediately when it goes low, phase_o is 0, tpa_o and mwr_o are 0, mrd_no is 1 and ma_o is 0. The cycle in progress when reset is released is idle.
- R2: phase_o advances by one on each rising clock edge, from 0 through 7. It wraps from 7 to 0, so a machine cycle is exactly 8 clocks.
- R3: addr_i, req_i and wr_i are sampled only at the edge where phase_o wraps from 7 to 0. Changes to them at any other phase have no effect on the outputs of the current cycle.
- R4: In every cycle, ma_o carries the sampled address bits [15:8] in phases 0 and 1, and bits [7:0] in phases 2 through 7.
- R5: In cycles with req_i=1, tpa_o is high for phase 1 only, and an external latch that captures ma_o while tpa_o is high holds bits [15:8]. In idle cycles (req_i=0), tpa_o stays low.
- R6: mrd_no is 0 for all eight phases of a read cycle (req_i=1, wr_i=0). It is 1 in write cycles and idle cycles.
- R7: mwr_o is 1 in phases 5 and 6 of a write cycle (req_i=1, wr_i=1) and 0 at every other time. While it is 1, ma_o does not change and mrd_no is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | Address for the next machine cycle |
| req_i | input | 1 | Memory access request for the next cycle |
| wr_i | input | 1 | 1 = write, 0 = read (meaningful when req_i=1) |
| ma_o | output | 8 | Multiplexed address byte |
| tpa_o | output | 1 | High-byte latch strobe |
| mrd_no | output | 1 | Active-low read level |
| mwr_o | output | 1 | Write pulse |
| phase_o | output | 3 | Clock phase within the machine cycle |

## Verification
Two functions can fall in the same cycle. The request for the next cycle is sampled at the same edge that ends the current cycle's strobes. A reset can also arrive while a write pulse is active.

The bench writes each new request at the phase-7 negative edge. Right after phase 0, it flips every input to its complement. It then checks that all eight phases of each cycle follow only the sampled values, including write cycles placed back to back with reads.

A reset pulled low in phase 5 of a write must clear the write pulse and the phase count before the next clock edge. After the reset is released, the cycle must run as idle.

// File: rtl/mcc_pkg.sv
`timescale 1ns/1ps
package mcc_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_kind_e;
endpackage

// File: rtl/mcc_phase_gen.sv
`timescale 1ns/1ps
module mcc_phase_gen #(
  parameter int PHASES = 8,
  parameter int PH_W   = $clog2(PHASES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PH_W-1:0] phase_o,
  output logic            last_o
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);

  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               phase_q <= '0;
    else if (phase_q == LAST_PH) phase_q <= '0;
    else                       phase_q <= phase_q + 1'b1;
  end

  assign phase_o = phase_q;
  assign last_o  = (phase_q == LAST_PH);

  p_phase_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (phase_q == '0));
  p_phase_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_o |=> (phase_q == $past(phase_q) + 1'b1));
endmodule

// File: rtl/mcc_cycle_reg.sv
`timescale 1ns/1ps
module mcc_cycle_reg
  import mcc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              req_i,
  input  logic              wr_i,
  output logic [ADDR_W-1:0] addr_o,
  output cyc_kind_e         kind_o
);
  logic [ADDR_W-1:0] addr_q;
  cyc_kind_e         kind_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      kind_q <= CYC_IDLE;
    end else if (load_i) begin
      addr_q <= addr_i;
      kind_q <= !req_i ? CYC_IDLE : (wr_i ? CYC_WRITE : CYC_READ);
    end
  end

  assign addr_o = addr_q;
  assign kind_o = kind_q;

  // inputs outside the cycle boundary must not leak in
  p_attr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(addr_q) && $stable(kind_q)));
endmodule

// File: rtl/mcc_strobe_gen.sv
`timescale 1ns/1ps
module mcc_strobe_gen
  import mcc_pkg::*;
#(
  parameter int PH_W     = 3,
  parameter int TPA_PH   = 1,
  parameter int WR_FIRST = 5,
  parameter int WR_LAST  = 6
) (
  input  logic [PH_W-1:0] phase_i,
  input  cyc_kind_e       kind_i,
  output logic            tpa_o,
  output logic            mrd_no,
  output logic            mwr_o
);
  localparam logic [PH_W-1:0] TPA_V = PH_W'(TPA_PH);
  localparam logic [PH_W-1:0] WR1_V = PH_W'(WR_FIRST);
  localparam logic [PH_W-1:0] WR2_V = PH_W'(WR_LAST);

  logic wr_window;

  always_comb begin
    wr_window = (phase_i >= WR1_V) && (phase_i <= WR2_V);
    tpa_o     = (kind_i != CYC_IDLE) && (phase_i == TPA_V);
    mrd_no    = (kind_i != CYC_READ);
    mwr_o     = (kind_i == CYC_WRITE) && wr_window;
  end
endmodule

// File: rtl/mem_cycle_ctrl.sv
`timescale 1ns/1ps
module mem_cycle_ctrl
  import mcc_pkg::*;
#(
  parameter int MA_W     = 8,
  parameter int ADDR_W   = 2 * MA_W,
  parameter int PHASES   = 8,
  parameter int PH_W     = $clog2(PHASES),
  parameter int TPA_PH   = 1,
  parameter int LOW_PH   = 2,
  parameter int WR_FIRST = 5,
  parameter int WR_LAST  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              req_i,
  input  logic              wr_i,
  output logic [MA_W-1:0]   ma_o,
  output logic              tpa_o,
  output logic              mrd_no,
  output logic              mwr_o,
  output logic [PH_W-1:0]   phase_o
);
  localparam logic [PH_W-1:0] LOW_V = PH_W'(LOW_PH);

  logic              last_ph;
  logic [ADDR_W-1:0] cyc_addr;
  cyc_kind_e         cyc_kind;

  mcc_phase_gen #(.PHASES(PHASES), .PH_W(PH_W)) i_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_o(phase_o),
    .last_o (last_ph)
  );

  mcc_cycle_reg #(.ADDR_W(ADDR_W)) i_cyc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(last_ph),
    .addr_i(addr_i),
    .req_i (req_i),
    .wr_i  (wr_i),
    .addr_o(cyc_addr),
    .kind_o(cyc_kind)
  );

  mcc_strobe_gen #(
    .PH_W(PH_W), .TPA_PH(TPA_PH), .WR_FIRST(WR_FIRST), .WR_LAST(WR_LAST)
  ) i_strb (
    .phase_i(phase_o),
    .kind_i (cyc_kind),
    .tpa_o  (tpa_o),
    .mrd_no (mrd_no),
    .mwr_o  (mwr_o)
  );

  // high byte before the low-byte switch point, low byte after
  assign ma_o = (phase_o < LOW_V) ? cyc_addr[ADDR_W-1 -: MA_W] : cyc_addr[MA_W-1:0];

  p_ma_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o > LOW_V) |-> $stable(ma_o));
  p_tpa_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tpa_o |=> !tpa_o);
  p_mrd_steady_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != '0) |-> $stable(mrd_no));
  p_rd_wr_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mwr_o && !mrd_no));
  p_mwr_settled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mwr_o |-> ($stable(ma_o) && !tpa_o));
endmodule

// File: tb/test_mem_cycle_ctrl.sv
`timescale 1ns/1ps
module test_mem_cycle_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = 16'h0;
  logic        req_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [7:0]  ma_o;
  logic        tpa_o, mrd_no, mwr_o;
  logic [2:0]  phase_o;

  int checks = 0;
  int fails  = 0;
  logic [7:0] hi_lat = 8'h0;

  always #2 clk_i = ~clk_i;

  mem_cycle_ctrl i_mem_cycle_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .req_i(req_i), .wr_i(wr_i),
    .ma_o(ma_o), .tpa_o(tpa_o), .mrd_no(mrd_no), .mwr_o(mwr_o), .phase_o(phase_o)
  );

  // external high-byte latch model
  always @(posedge clk_i) if (tpa_o) hi_lat <= ma_o;

  // {req, wr, addr}
  localparam logic [17:0] VEC [6] = '{
    {1'b1, 1'b0, 16'h12A5},
    {1'b1, 1'b1, 16'hFF00},
    {1'b0, 1'b0, 16'h5A5A},
    {1'b1, 1'b1, 16'h00FF},
    {1'b1, 1'b0, 16'h8001},
    {1'b1, 1'b1, 16'hC33C}
  };

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // entered at the negedge of phase 7; leaves at the negedge of the next phase 7
  task automatic run_cycle(input logic rq, input logic w, input logic [15:0] a);
    req_i = rq; wr_i = w; addr_i = a;
    for (int p = 0; p < 8; p++) begin
      @(negedge clk_i);
      chk("R2", "phase", 16'(phase_o), 16'(p));
      chk("R4", "ma", 16'(ma_o), 16'((p < 2) ? a[15:8] : a[7:0]));
      chk("R5", "tpa", 16'(tpa_o), 16'(rq && p == 1));
      chk("R6", "mrd_n", 16'(mrd_no), 16'(!(rq && !w)));
      chk("R7", "mwr", 16'(mwr_o), 16'(rq && w && (p == 5 || p == 6)));
      if (rq && p >= 2) chk("R5", "latched addr", {hi_lat, ma_o}, a);
      if (p == 0) begin
        // R3: complement inputs mid-cycle
        addr_i = ~a; req_i = ~rq; wr_i = ~w;
      end
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    req_i = 1'b1; wr_i = 1'b0; addr_i = 16'hBEEF;
    repeat (3) @(negedge clk_i);
    chk("R1", "reset phase", 16'(phase_o), 16'd0);
    chk("R1", "reset tpa", 16'(tpa_o), 16'd0);
    chk("R1", "reset mwr", 16'(mwr_o), 16'd0);
    chk("R1", "reset mrd_n", 16'(mrd_no), 16'd1);
    chk("R1", "reset ma", 16'(ma_o), 16'd0);
    rst_ni = 1'b1;
    // first cycle after release is idle even with a read requested
    for (int p = 1; p < 8; p++) begin
      @(negedge clk_i);
      chk("R2", "phase after reset", 16'(phase_o), 16'(p));
      chk("R1", "idle mrd_n", 16'(mrd_no), 16'd1);
      chk("R1", "idle tpa", 16'(tpa_o), 16'd0);
    end
    for (int i = 0; i < 6; i++) run_cycle(VEC[i][17], VEC[i][16], VEC[i][15:0]);

    // reset during an active write pulse
    req_i = 1'b1; wr_i = 1'b1; addr_i = 16'h7E81;
    repeat (6) @(negedge clk_i);
    chk("R7", "mwr before reset", 16'(mwr_o), 16'd1);
    rst_ni = 1'b0;
    #0.5;
    chk("R1", "async mwr", 16'(mwr_o), 16'd0);
    chk("R1", "async phase", 16'(phase_o), 16'd0);
    chk("R1", "async mrd_n", 16'(mrd_no), 16'd1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int k = 0; k < 16 && phase_o != 3'd7; k++) begin
      @(negedge clk_i);
      chk("R1", "post-reset mwr", 16'(mwr_o), 16'd0);
    end
    run_cycle(1'b1, 1'b0, 16'h3C96);
    run_cycle(1'b1, 1'b1, 16'hA55A);
    finish_run();
  end
endmodule